// File: doc/BRIEF.md
# Display Transmitter Interrupt and Soft-Reset Controller

This block collects single-cycle event pulses from a display transmitter, and two level inputs, into one interrupt line. Each event sets its own sticky pending bit, whether or not that bit is enabled. The interrupt line is raised while any pending bit is also enabled. Software reads the pending bits through a status register, picks which ones reach the line through an enable register, and clears them by writing ones to a separate clear register.

The same register bus also drives a soft-reset request bit in a configuration register. Completion is reported, as a live status bit and as a sticky interrupt bit, only while the request is held and an auxiliary clock is present. The auxiliary clock indication and the hot-plug level arrive asynchronously, so both pass through synchronizers. Either edge of the synchronized hot-plug level sets its pending bit. The register bus is a 32-bit write strobe with address and data, and reads are combinational from the address.

Top module: `disp_irq_ctrl`

## Requirements
- R1: Register byte offsets are fixed: configuration 0x000 (read/write, 32 bits), interrupt enable 0x004, interrupt status 0x008, interrupt clear 0x00C (always reads 0) and general status 0x010. After reset every register reads 0 and `irq` is low.
- R2: A one-cycle pulse on an event input sets its status bit at the next rising clock edge, even when that bit is disabled. The bit positions are: pixel capture 3, DLL lock 5, new frame 6, control packet 7, sink termination 11.
- R3: `irq` is high exactly while some status bit other than bit 0 is both pending and enabled. It follows enable writes with no extra delay.
- R4: Writing a value to the clear register clears every pending bit where that value holds a one and leaves the others alone. Writing 0xFFFFFFFF clears all of them.
- R5: An event in the same cycle as a clear write that targets its bit leaves the bit set.
- R6: Status bit 0 (global) reads as the OR of all enabled pending bits 1 to 31. It is never stored, so writing a one to bit 0 of the clear register changes nothing.
- R7: With configuration bit 31 set and the auxiliary clock present, general status bit 1 reads 1 within a few cycles and status bit 1 (reset done) becomes pending. Clearing bit 31 drops general status bit 1.
- R8: While the auxiliary clock input stays low, general status bit 1 and status bit 1 stay 0, however long the request is held.
- R9: General status bit 4 reads the synchronized hot-plug level. Each rising or falling edge of that level sets status bit 4.
- R10: The enable register stores only bits 0, 1, 3, 4, 5, 6, 7 and 11 (mask 0x8FB). All other bits read 0.
- R11: Writes to the status register and to the general status register have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_pix_cap | input | 1 | Pixel capture event pulse |
| evt_dll_lock | input | 1 | DLL lock event pulse |
| evt_new_frame | input | 1 | New frame event pulse |
| evt_ctrl_pkt | input | 1 | Control packet sent event pulse |
| evt_sink_term | input | 1 | Sink termination present event pulse |
| hpd_level | input | 1 | Asynchronous hot-plug level |
| aux_clk_on | input | 1 | Asynchronous indication that the auxiliary clock is running |
| irq | output | 1 | Interrupt line |

## Verification
The bench drives an event in the same cycle as a clear write. A design that let the clear win would silently lose that event. It holds the soft-reset request with the auxiliary clock absent for many cycles. A design that ignored the clock condition would report a completion that never happened. It toggles the hot-plug level both ways, which catches a design that only detects the rising edge. It also writes the all-ones clear, bit 0 of the clear register, the read-only registers and an all-ones enable value, which exposes a stored global bit, leaking unimplemented enable bits, or writes that reach the wrong register. Random pulse and write mixes are compared every other cycle against a model of status and `irq`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW = 32;

  // byte offsets
  localparam int OFF_CFG  = 'h000;
  localparam int OFF_EN   = 'h004;
  localparam int OFF_STA  = 'h008;
  localparam int OFF_CLR  = 'h00C;
  localparam int OFF_GSTA = 'h010;

  // interrupt bit map
  localparam int B_GLOBAL = 0;
  localparam int B_SWRST  = 1;
  localparam int B_PIXCAP = 3;
  localparam int B_HPD    = 4;
  localparam int B_DLL    = 5;
  localparam int B_FRAME  = 6;
  localparam int B_PKT    = 7;
  localparam int B_SINK   = 11;

  localparam int CFG_SWRST_BIT = 31;
  localparam int GSTA_DONE_BIT = 1;
  localparam int GSTA_HPD_BIT  = 4;

  localparam logic [DW-1:0] EN_MASK =
    (DW'(1) << B_GLOBAL) | (DW'(1) << B_SWRST) | (DW'(1) << B_PIXCAP) |
    (DW'(1) << B_HPD)    | (DW'(1) << B_DLL)   | (DW'(1) << B_FRAME)  |
    (DW'(1) << B_PKT)    | (DW'(1) << B_SINK);
  localparam logic [DW-1:0] PEND_MASK = EN_MASK & ~(DW'(1) << B_GLOBAL);

  typedef enum logic [2:0] {
    SEL_CFG, SEL_EN, SEL_STA, SEL_CLR, SEL_GSTA, SEL_NONE
  } reg_sel_e;

  function automatic logic any_enabled(input logic [DW-1:0] pend,
                                       input logic [DW-1:0] en);
    return |(pend & en & PEND_MASK);
  endfunction

  function automatic logic [DW-1:0] status_view(input logic [DW-1:0] pend,
                                                input logic [DW-1:0] en);
    logic [DW-1:0] v;
    v = pend & PEND_MASK;
    v[B_GLOBAL] = any_enabled(pend, en);
    return v;
  endfunction

  function automatic logic [DW-1:0] next_pending(input logic [DW-1:0] pend,
                                                 input logic [DW-1:0] set,
                                                 input logic [DW-1:0] clr);
    return ((pend & ~clr) | set) & PEND_MASK;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     sta_view,
  input  logic [DW-1:0]     gsta_view,
  output logic [DW-1:0]     cfg_q,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     clr_mask,
  output logic [DW-1:0]     rdata
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(OFF_STA);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_GSTA = ADDR_W'(OFF_GSTA);

  reg_sel_e sel;

  always_comb begin
    case (addr)
      A_CFG:   sel = SEL_CFG;
      A_EN:    sel = SEL_EN;
      A_STA:   sel = SEL_STA;
      A_CLR:   sel = SEL_CLR;
      A_GSTA:  sel = SEL_GSTA;
      default: sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else if (wr) begin
      if (sel == SEL_CFG) cfg_q <= wdata;
      if (sel == SEL_EN)  en_q  <= wdata & EN_MASK;
    end
  end

  assign clr_mask = (wr && sel == SEL_CLR) ? (wdata & PEND_MASK) : '0;

  always_comb begin
    case (sel)
      SEL_CFG:  rdata = cfg_q;
      SEL_EN:   rdata = en_q;
      SEL_STA:  rdata = sta_view;
      SEL_GSTA: rdata = gsta_view;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= next_pending(pend_q, set_vec, clr_mask);
  end
endmodule

// File: rtl/irqc_swrst.sv
module irqc_swrst (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic aux_ok,
  output logic done_q,
  output logic done_rise
);
  logic done_d;

  assign done_d    = req & aux_ok;
  assign done_rise = done_d & ~done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_pix_cap,
  input  logic              evt_dll_lock,
  input  logic              evt_new_frame,
  input  logic              evt_ctrl_pkt,
  input  logic              evt_sink_term,
  input  logic              hpd_level,
  input  logic              aux_clk_on,
  output logic              irq
);
  logic [1:0]    async_in, sync_out;
  logic          aux_s, hpd_s, hpd_d, hpd_edge;
  logic          done_q, done_rise;
  logic [DW-1:0] cfg_q, en_q, clr_mask, pend_q, set_vec, sta_view, gsta_view;

  assign async_in = {hpd_level, aux_clk_on};

  irqc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );
  assign aux_s = sync_out[0];
  assign hpd_s = sync_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hpd_d <= 1'b0;
    else        hpd_d <= hpd_s;
  end
  assign hpd_edge = hpd_s ^ hpd_d;

  irqc_swrst u_swrst (
    .clk(clk), .rst_n(rst_n), .req(cfg_q[CFG_SWRST_BIT]), .aux_ok(aux_s),
    .done_q(done_q), .done_rise(done_rise)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_SWRST]  = done_rise;
    set_vec[B_PIXCAP] = evt_pix_cap;
    set_vec[B_HPD]    = hpd_edge;
    set_vec[B_DLL]    = evt_dll_lock;
    set_vec[B_FRAME]  = evt_new_frame;
    set_vec[B_PKT]    = evt_ctrl_pkt;
    set_vec[B_SINK]   = evt_sink_term;
  end

  irqc_status u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_mask(clr_mask),
    .pend_q(pend_q)
  );

  assign sta_view = status_view(pend_q, en_q);

  always_comb begin
    gsta_view                = '0;
    gsta_view[GSTA_DONE_BIT] = done_q;
    gsta_view[GSTA_HPD_BIT]  = hpd_s;
  end

  irqc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .sta_view(sta_view), .gsta_view(gsta_view), .cfg_q(cfg_q), .en_q(en_q),
    .clr_mask(clr_mask), .rdata(bus_rdata)
  );

  assign irq = any_enabled(pend_q, en_q);
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic evt_pix,
  input logic clr_pix,
  input logic pend_pix,
  input logic en_pix,
  input logic pend_glob,
  input logic pend_done,
  input logic pend_hpd,
  input logic done_q,
  input logic aux_s,
  input logic hpd_s,
  input logic irq
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pix |=> pend_pix); // R2
  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pix && clr_pix) |=> pend_pix); // R5
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pix && !evt_pix) |=> !pend_pix); // R4
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_pix && en_pix) |-> irq); // R3
  AST_GLOBAL_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_glob); // R6
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> pend_done); // R7
  AST_NO_AUX_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(aux_s) |-> !done_q); // R8
  AST_HPD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hpd_s) |=> pend_hpd); // R9
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .evt_pix(evt_pix_cap),
  .clr_pix(clr_mask[irqc_pkg::B_PIXCAP]), .pend_pix(pend_q[irqc_pkg::B_PIXCAP]),
  .en_pix(en_q[irqc_pkg::B_PIXCAP]), .pend_glob(pend_q[irqc_pkg::B_GLOBAL]),
  .pend_done(pend_q[irqc_pkg::B_SWRST]), .pend_hpd(pend_q[irqc_pkg::B_HPD]),
  .done_q(done_q), .aux_s(aux_s), .hpd_s(hpd_s), .irq(irq)
);

// File: tb/disp_irq_ctrl_tb_top.sv
module disp_irq_ctrl_tb_top;
  localparam int AW = 12;
  localparam logic [31:0] M_EN   = 32'h0000_08FB;
  localparam logic [31:0] M_PEND = 32'h0000_08FA;
  localparam logic [AW-1:0] A_CFG = 12'h000, A_EN = 12'h004, A_STA = 12'h008,
                            A_CLR = 12'h00C, A_GSTA = 12'h010;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic e_pix = 0, e_dll = 0, e_frm = 0, e_pkt = 0, e_snk = 0, hpd = 0, aux = 0;
  logic irq;

  disp_irq_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pix_cap(e_pix),
    .evt_dll_lock(e_dll), .evt_new_frame(e_frm), .evt_ctrl_pkt(e_pkt),
    .evt_sink_term(e_snk), .hpd_level(hpd), .aux_clk_on(aux), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] m_pend = '0, m_en = '0, rd_v;

  function automatic logic [31:0] m_view(logic [31:0] p, logic [31:0] e);
    logic [31:0] v = p & M_PEND;
    v[0] = ((p & e & M_PEND) != 0);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_CFG, rd_v);  check("R1 cfg", rd_v, 0);
    rd(A_EN, rd_v);   check("R1 en", rd_v, 0);
    rd(A_STA, rd_v);  check("R1 sta", rd_v, 0);
    rd(A_CLR, rd_v);  check("R1 clr", rd_v, 0);
    rd(A_GSTA, rd_v); check("R1 gsta", rd_v, 0);
    check("R1 irq", irq, 0);
    wr(A_CFG, 32'h1234_5670);
    rd(A_CFG, rd_v);  check("R1 cfg rw", rd_v, 32'h1234_5670);
    wr(A_CFG, 0);

    // R10 enable mask
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, rd_v); check("R10 en mask", rd_v, M_EN);
    wr(A_EN, 0);

    // R2 exact timing, disabled bit still latched
    e_pix = 1; #1;
    check("R2 irq before edge", irq, 0);
    @(negedge clk); e_pix = 0;
    rd(A_STA, rd_v); check("R2 pix latched disabled", rd_v, 32'h8);
    check("R3 irq disabled", irq, 0);
    wr(A_EN, 32'h8);
    check("R3 irq after enable", irq, 1);
    rd(A_STA, rd_v); check("R6 global", rd_v, 32'h9);

    // R6 clear bit0 only
    wr(A_CLR, 32'h1);
    rd(A_STA, rd_v); check("R6 clr bit0 no effect", rd_v, 32'h9);

    // R11 read-only writes
    wr(A_STA, 32'h0);
    wr(A_GSTA, 32'hFFFF_FFFF);
    rd(A_STA, rd_v);  check("R11 sta write ignored", rd_v, 32'h9);
    rd(A_GSTA, rd_v); check("R11 gsta write ignored", rd_v, 0);
    rd(A_EN, rd_v);   check("R11 en untouched", rd_v, 32'h8);

    // R5 event beats clear
    e_pix = 1;
    wr(A_CLR, 32'hFFFF_FFFF);
    e_pix = 0;
    rd(A_STA, rd_v); check("R5 event wins", rd_v, 32'h9);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STA, rd_v); check("R4 all ones clears", rd_v, 0);
    check("R3 irq low", irq, 0);

    // R8 soft reset without aux clock
    wr(A_CFG, 32'h8000_0000);
    repeat (40) @(negedge clk);
    rd(A_GSTA, rd_v); check("R8 no done without aux", rd_v[1], 0);
    rd(A_STA, rd_v);  check("R8 no done irq bit", rd_v[1], 0);

    // R7 aux present
    aux = 1;
    repeat (6) @(negedge clk);
    rd(A_GSTA, rd_v); check("R7 done live", rd_v[1], 1);
    rd(A_STA, rd_v);  check("R7 done pending", rd_v, 32'h2);
    wr(A_EN, 32'h2);
    check("R7 irq on done", irq, 1);
    wr(A_CFG, 0);
    repeat (2) @(negedge clk);
    rd(A_GSTA, rd_v); check("R7 done drops", rd_v[1], 0);
    rd(A_STA, rd_v);  check("R7 pending sticky", rd_v, 32'h3);
    wr(A_CLR, 32'h2);
    rd(A_STA, rd_v);  check("R4 clear done", rd_v, 0);
    aux = 0;

    // R9 hot plug both edges
    hpd = 1;
    repeat (5) @(negedge clk);
    rd(A_GSTA, rd_v); check("R9 hpd live high", rd_v[4], 1);
    rd(A_STA, rd_v);  check("R9 rise sets", rd_v[4], 1);
    wr(A_CLR, 32'h10);
    rd(A_STA, rd_v);  check("R9 cleared", rd_v[4], 0);
    hpd = 0;
    repeat (5) @(negedge clk);
    rd(A_GSTA, rd_v); check("R9 hpd live low", rd_v[4], 0);
    rd(A_STA, rd_v);  check("R9 fall sets", rd_v[4], 1);
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_EN, 0);

    // random mix: R2 R3 R4 R5
    m_pend = 0; m_en = 0;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r, wd, setm, clrm;
      int op;
      r = $urandom; wd = $urandom; op = $urandom_range(0, 3);
      e_pix = r[0] & r[1]; e_dll = r[2] & r[3]; e_frm = r[4] & r[5];
      e_pkt = r[6] & r[7]; e_snk = r[8] & r[9];
      setm = 0;
      setm[3] = e_pix; setm[5] = e_dll; setm[6] = e_frm;
      setm[7] = e_pkt; setm[11] = e_snk;
      clrm = 0;
      if (op == 3) wd = 32'hFFFF_FFFF;
      if (op == 1) begin
        wr(A_EN, wd);
        m_en = wd & M_EN;
      end else if (op >= 2) begin
        wr(A_CLR, wd);
        clrm = wd;
      end else begin
        @(negedge clk);
      end
      e_pix = 0; e_dll = 0; e_frm = 0; e_pkt = 0; e_snk = 0;
      m_pend = ((m_pend & ~clrm) | setm) & M_PEND;
      rd(A_STA, rd_v); check("R2 R4 R5 random status", rd_v, m_view(m_pend, m_en));
      check("R3 random irq", irq, m_view(m_pend, m_en)[0]);
      @(negedge clk);
    end
    finish_run();
  end
endmodule